// File: doc/BRIEF.md
# Ring Oscillator Response Generator

This block turns a bank of ring oscillators into a fixed-length device response. The oscillators are compared in disjoint pairs, so an array of 200 oscillators yields 100 independent bits. The oscillators themselves sit outside the block. The block gives each one an enable line, and it takes each one's free-running output back as an input. The block measures one oscillator at a time. It raises that oscillator's enable and routes its output through two selection multiplexers to a single edge counter. The counter counts rising edges over a gate window of a fixed number of system-clock cycles.

A run begins when `start` is pulsed. The pairs are measured in index order, and within each pair the first member is measured before the second. The two counts are compared, and the result bit goes into a working shift register. When the last pair is done, the whole word is copied to `response` and `done` pulses for one cycle. Which physical oscillators form each pair is set when the block is built, through a pairing table parameter. By default, pair k uses oscillator k first and oscillator N_OSC-1-k second.

Top module: `ropuf_response_gen`

## Requirements
- R1: While reset is held low and on the first cycle after it, `response` is all zeros, `done` is 0 and every bit of `osc_en` is 0.
- R2: At most one bit of `osc_en` is 1 in any cycle, and in the cycle where `done` is 1 every bit of `osc_en` is 0.
- R3: For pair k, the first oscillator enabled is the one in table slot 2k and the second is the one in slot 2k+1. With the default table, slot 2k holds k and slot 2k+1 holds N_OSC-1-k. Pairs run in order k = 0, 1, ..., N_OSC/2-1.
- R4: Each oscillator's frequency is taken as the number of its rising edges seen during GATE_CYCLES system-clock cycles. The count window opens after SETTLE_CYCLES cycles with the count held at zero. The result bit is 1 only when the first member's count is strictly greater than the second's. Equal counts give 0.
- R5: The result of pair k is placed at `response[k]`, so pair 0 lands in the least significant bit.
- R6: `start` is sampled at a rising clock edge while the block is idle. `done` is then high for exactly one cycle, beginning N_OSC*(SETTLE_CYCLES+GATE_CYCLES+1) clock edges after that edge. The new response is present on `response` in that same cycle.
- R7: `response` changes only in the cycle where `done` is 1. Between runs and during a run it keeps the previous result.
- R8: A `start` pulse that arrives while a run is in progress is ignored. The current run neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a full run |
| osc_in | input | N_OSC | Raw outputs of the oscillator array |
| osc_en | output | N_OSC | One-hot enable, one line per oscillator |
| response | output | N_OSC/2 | Completed response word, bit k from pair k |
| done | output | 1 | One-cycle pulse when `response` holds a new result |

## Verification
The oscillators are modelled as gated clocks. Each one starts a fixed fraction of a nanosecond after its enable rises and stops when the enable falls. Every pair is given one of three period relations: first member faster, first member slower, or identical periods. Identical periods with identical start phase give identical counts, so the strict comparison and the 0 result for ties can be checked deterministically.

The first run alternates faster and slower first members. This separates a correct bit order from a reversed or shifted one, and it also shows whether the comparison is reversed. The second run uses a period-three pattern that mixes ties with both orderings, and a stray start pulse arrives partway through it. Throughout both runs, the order in which enable lines rise is logged and compared against the pairing table. The number of cycles to `done` is also checked, as is the stability of the previous response.

// File: rtl/ropuf_pkg.sv
`timescale 1ns/1ps
// ropuf_pkg: shared types and the default pairing table for the response generator.
// Assumes at most MAX_OSC oscillators; each table slot is SLOT_W bits wide.
package ropuf_pkg;
    localparam int SLOT_W  = 16;
    localparam int MAX_OSC = 256;
    localparam int MAP_W   = SLOT_W * MAX_OSC;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARM   = 2'd1,
        SQ_GATE  = 2'd2,
        SQ_LATCH = 2'd3
    } seq_state_t;

    // Default table: pair k compares oscillator k (slot 2k) with oscillator n-1-k (slot 2k+1).
    function automatic logic [MAP_W-1:0] mirror_map(input int n_osc);
        logic [MAP_W-1:0] m;
        m = '0;
        for (int k = 0; k < n_osc / 2; k++) begin
            m[(2*k)*SLOT_W +: SLOT_W]   = SLOT_W'(k);
            m[(2*k+1)*SLOT_W +: SLOT_W] = SLOT_W'(n_osc - 1 - k);
        end
        return m;
    endfunction
endpackage

// File: rtl/ropuf_sequencer.sv
`timescale 1ns/1ps
// ropuf_sequencer: steps through every pair, first member then second member.
// Each measurement is SETTLE cycles with the counter held clear, then GATE
// counting cycles, then one latch cycle. A start pulse seen outside the idle state is ignored.
module ropuf_sequencer #(
    parameter int N_PAIR        = 100,
    parameter int GATE_CYCLES   = 128,
    parameter int SETTLE_CYCLES = 4,
    localparam int PAIR_W = (N_PAIR > 1) ? $clog2(N_PAIR) : 1,
    localparam int TMR_W  = $clog2(GATE_CYCLES + SETTLE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [PAIR_W-1:0] pair_idx,
    output logic              second,
    output logic              osc_run,
    output logic              cnt_clr,
    output logic              cnt_en,
    output logic              sample_stb,
    output logic              sample_last
);
    import ropuf_pkg::*;

    seq_state_t        state;
    logic [TMR_W-1:0]  tmr;

    // Measurement state machine with its cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            pair_idx <= '0;
            second   <= 1'b0;
            tmr      <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    state    <= SQ_ARM;
                    pair_idx <= '0;
                    second   <= 1'b0;
                    tmr      <= '0;
                end
                SQ_ARM: if (tmr == TMR_W'(SETTLE_CYCLES - 1)) begin
                    state <= SQ_GATE;
                    tmr   <= '0;
                end else begin
                    tmr <= tmr + 1'b1;
                end
                SQ_GATE: if (tmr == TMR_W'(GATE_CYCLES - 1)) begin
                    state <= SQ_LATCH;
                    tmr   <= '0;
                end else begin
                    tmr <= tmr + 1'b1;
                end
                default: begin
                    if (!second) begin
                        second <= 1'b1;
                        state  <= SQ_ARM;
                    end else if (pair_idx == PAIR_W'(N_PAIR - 1)) begin
                        second <= 1'b0;
                        state  <= SQ_IDLE;
                    end else begin
                        second   <= 1'b0;
                        pair_idx <= pair_idx + 1'b1;
                        state    <= SQ_ARM;
                    end
                end
            endcase
        end
    end

    // Control strobes decoded from the current state.
    always_comb begin
        osc_run     = (state == SQ_ARM) || (state == SQ_GATE);
        cnt_clr     = (state == SQ_ARM);
        cnt_en      = (state == SQ_GATE);
        sample_stb  = (state == SQ_LATCH);
        sample_last = (state == SQ_LATCH) && second && (pair_idx == PAIR_W'(N_PAIR - 1));
    end
endmodule

// File: rtl/ropuf_edge_counter.sv
`timescale 1ns/1ps
// ropuf_edge_counter: counts rising edges of the selected oscillator signal.
// A toggle flop in the oscillator domain goes through a two-flop synchroniser,
// and one more stage detects each change, so each edge gives one pulse.
// Assumes the oscillator period exceeds two system-clock periods. The toggle
// flop is the only asynchronously cleared flop, since its clock is stopped during reset.
module ropuf_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_clk,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    logic       tgl;
    logic [2:0] sync_q;
    logic       edge_pulse;

    // Flip once per rising edge of the measured oscillator.
    always_ff @(posedge meas_clk or negedge rst_n) begin
        if (!rst_n) tgl <= 1'b0;
        else        tgl <= ~tgl;
    end

    // Bring the toggle into the system-clock domain and keep one extra stage for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tgl};
    end

    assign edge_pulse = sync_q[2] ^ sync_q[1];

    // Clear before the window, count change pulses inside it, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      count <= '0;
        else if (en && edge_pulse) count <= count + 1'b1;
    end
endmodule

// File: rtl/ropuf_compare_shift.sv
`timescale 1ns/1ps
// ropuf_compare_shift: keeps the first member's count, compares it with the second,
// and shifts the bit in from the top, so after N_PAIR bits pair 0 sits in bit 0.
// On the final bit it copies the word to the output and pulses done.
module ropuf_compare_shift #(
    parameter int N_PAIR = 100,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              second,
    input  logic              last,
    input  logic [CNT_W-1:0]  count,
    output logic [N_PAIR-1:0] response,
    output logic              done
);
    logic [CNT_W-1:0]  first_cnt;
    logic [N_PAIR-1:0] work;
    logic [N_PAIR-1:0] work_next;
    logic              win;

    // Strict comparison, so a tie resolves to 0.
    always_comb begin
        win       = (first_cnt > count);
        work_next = {win, work[N_PAIR-1:1]};
    end

    // Hold the first count, shift results, publish the word at the end of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_cnt <= '0;
            work      <= '0;
            response  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (stb && !second) begin
                first_cnt <= count;
            end else if (stb) begin
                work <= work_next;
                if (last) begin
                    response <= work_next;
                    done     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ropuf_response_gen.sv
`timescale 1ns/1ps
// ropuf_response_gen: top of the ring oscillator response generator.
// Decodes the pairing table, drives the registered one-hot enable, routes the
// selected oscillator through the first- and second-member multiplexers to the counter.
// Assumes every table entry used is below N_OSC.
module ropuf_response_gen #(
    parameter int N_OSC         = 200,
    parameter int GATE_CYCLES   = 128,
    parameter int SETTLE_CYCLES = 4,
    parameter logic [ropuf_pkg::MAP_W-1:0] PAIR_MAP = ropuf_pkg::mirror_map(N_OSC),
    localparam int N_PAIR = N_OSC / 2,
    localparam int IDX_W  = $clog2(N_OSC),
    localparam int PAIR_W = (N_PAIR > 1) ? $clog2(N_PAIR) : 1,
    localparam int CNT_W  = $clog2(GATE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_OSC-1:0]  osc_in,
    output logic [N_OSC-1:0]  osc_en,
    output logic [N_PAIR-1:0] response,
    output logic              done
);
    import ropuf_pkg::*;

    logic [PAIR_W-1:0] pair_idx;
    logic              second, osc_run, cnt_clr, cnt_en, sample_stb, sample_last;
    logic [IDX_W-1:0]  idx_a, idx_b, cur_idx;
    logic              mux_a, mux_b, meas_sig;
    logic [CNT_W-1:0]  count;

    ropuf_sequencer #(
        .N_PAIR(N_PAIR), .GATE_CYCLES(GATE_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pair_idx(pair_idx), .second(second), .osc_run(osc_run),
        .cnt_clr(cnt_clr), .cnt_en(cnt_en),
        .sample_stb(sample_stb), .sample_last(sample_last)
    );

    // Table lookup and the two member multiplexers, then the phase select.
    always_comb begin
        idx_a    = PAIR_MAP[(32'(pair_idx) * 2) * SLOT_W +: IDX_W];
        idx_b    = PAIR_MAP[(32'(pair_idx) * 2 + 1) * SLOT_W +: IDX_W];
        mux_a    = osc_in[idx_a];
        mux_b    = osc_in[idx_b];
        meas_sig = second ? mux_b : mux_a;
        cur_idx  = second ? idx_b : idx_a;
    end

    // One registered enable per oscillator, high only for the one being measured.
    for (genvar i = 0; i < N_OSC; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) osc_en[i] <= 1'b0;
            else        osc_en[i] <= osc_run && (cur_idx == IDX_W'(i));
        end
    end

    ropuf_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .meas_clk(meas_sig),
        .clr(cnt_clr), .en(cnt_en), .count(count)
    );

    ropuf_compare_shift #(.N_PAIR(N_PAIR), .CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .stb(sample_stb), .second(second),
        .last(sample_last), .count(count), .response(response), .done(done)
    );
endmodule

// File: rtl/ropuf_checker.sv
`timescale 1ns/1ps
// ropuf_checker: port-level properties of the response generator, bound to the top.
module ropuf_checker #(
    parameter int N_OSC  = 200,
    parameter int N_PAIR = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_OSC-1:0]  osc_en,
    input logic [N_PAIR-1:0] response,
    input logic              done
);
    // R2: never two oscillators running together.
    a_r2_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(osc_en));

    // R2: the array is silent when the result is published.
    a_r2_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (osc_en == '0));

    // R6: done lasts a single cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the word moves only together with done.
    a_r7_response_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(response));
endmodule

bind ropuf_response_gen ropuf_checker #(.N_OSC(N_OSC), .N_PAIR(N_OSC / 2)) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .response(response), .done(done)
);

// File: tb/ropuf_response_gen_test.sv
`timescale 1ns/1ps
// Directed bench: oscillators are gated clocks whose periods are set per scenario.
module ropuf_response_gen_test;
    localparam int N_OSC    = 200;
    localparam int N_PAIR   = 100;
    localparam int GATE     = 128;
    localparam int SETTLE   = 4;
    localparam int MEAS_LEN = GATE + SETTLE + 1;
    localparam int RUN_LEN  = N_OSC * MEAS_LEN;
    localparam real P_FAST  = 25.0;
    localparam real P_SLOW  = 41.0;
    localparam real P_TIE   = 33.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N_OSC-1:0]  osc_in;
    logic [N_OSC-1:0]  osc_en;
    logic [N_PAIR-1:0] response;
    logic              done;

    real period_ns [N_OSC];
    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    int  order_log [N_OSC];
    int  log_n = 0;
    int  multi_en = 0;
    logic [N_OSC-1:0] en_prev = '0;

    always #4 clk = ~clk;

    ropuf_response_gen #(.N_OSC(N_OSC), .GATE_CYCLES(GATE), .SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .osc_in(osc_in),
        .osc_en(osc_en), .response(response), .done(done)
    );

    // Gated oscillator models: start 0.3 ns after enable, stop low when disabled.
    for (genvar g = 0; g < N_OSC; g++) begin : g_osc
        logic o = 1'b0;
        always begin
            o = 1'b0;
            wait (osc_en[g] == 1'b1);
            #0.3;
            while (osc_en[g]) begin
                #(period_ns[g] / 2.0) o = 1'b1;
                #(period_ns[g] / 2.0) o = 1'b0;
            end
        end
        assign osc_in[g] = o;
    end

    // Enable monitor at the falling edge: log each newly raised line, count overlaps.
    always @(negedge clk) begin
        if ($countones(osc_en) > 1) multi_en++;
        if (en_prev == '0 && osc_en != '0) begin
            for (int i = 0; i < N_OSC; i++)
                if (osc_en[i] && log_n < N_OSC) begin
                    order_log[log_n] = i;
                    log_n++;
                end
        end
        en_prev = osc_en;
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        repeat (5) @(negedge clk);
        check(response == '0, "R1 response", 128'(response), 0);
        check(done == 1'b0, "R1 done", 128'(done), 0);
        check(osc_en == '0, "R1 osc_en", 128'(osc_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(response == '0 && done == 1'b0 && osc_en == '0, "R1 after release",
              128'(response), 0);
    endtask

    // Runs one full response and checks timing, order, result and hold behaviour.
    task automatic do_run(input string tag, input logic [N_PAIR-1:0] exp,
                          input logic [N_PAIR-1:0] prev, input bit stray_start);
        int  n;
        bit  held;
        bit  order_ok;
        log_n    = 0;
        multi_en = 0;
        held     = 1'b1;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!done && n < RUN_LEN + 50) begin
            if (response != prev) held = 1'b0;
            if (stray_start && n == 1000) start = 1'b1;
            if (stray_start && n == 1001) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check(n == RUN_LEN, {tag, " R6 latency to done"}, 128'(n), 128'(RUN_LEN));
        if (stray_start)
            check(n == RUN_LEN, {tag, " R8 stray start ignored"}, 128'(n), 128'(RUN_LEN));
        check(held, {tag, " R7 previous response held during run"}, 128'(held), 1);
        check(response == exp, {tag, " R4 R5 response word"}, 128'(response), 128'(exp));
        check(osc_en == '0, {tag, " R2 silent at done"}, 128'(osc_en), 0);
        check(multi_en == 0, {tag, " R2 one enable at a time"}, 128'(multi_en), 0);
        order_ok = (log_n == N_OSC);
        for (int k = 0; k < N_PAIR; k++) begin
            if (order_log[2*k] != k) order_ok = 1'b0;
            if (order_log[2*k+1] != N_OSC - 1 - k) order_ok = 1'b0;
        end
        check(order_ok, {tag, " R3 enable order"}, 128'(log_n), 128'(N_OSC));
        @(negedge clk);
        check(done == 1'b0, {tag, " R6 done one cycle"}, 128'(done), 0);
    endtask

    task automatic test_alternating(output logic [N_PAIR-1:0] exp);
        for (int k = 0; k < N_PAIR; k++) begin
            period_ns[k]           = (k % 2 == 0) ? P_FAST : P_SLOW;
            period_ns[N_OSC-1-k]   = (k % 2 == 0) ? P_SLOW : P_FAST;
            exp[k]                 = (k % 2 == 0);
        end
        do_run("alternating", exp, '0, 1'b0);
    endtask

    task automatic test_mixed_ties(input logic [N_PAIR-1:0] prev);
        logic [N_PAIR-1:0] exp;
        for (int k = 0; k < N_PAIR; k++) begin
            case (k % 3)
                0: begin period_ns[k] = P_TIE;  period_ns[N_OSC-1-k] = P_TIE;  exp[k] = 1'b0; end
                1: begin period_ns[k] = P_FAST; period_ns[N_OSC-1-k] = P_SLOW; exp[k] = 1'b1; end
                default: begin period_ns[k] = P_SLOW; period_ns[N_OSC-1-k] = P_FAST; exp[k] = 1'b0; end
            endcase
        end
        do_run("mixed_ties R4 equal gives 0", exp, prev, 1'b1);
        test_idle_hold(exp);
    endtask

    task automatic test_idle_hold(input logic [N_PAIR-1:0] exp);
        bit no_done = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (done) no_done = 1'b0;
        end
        check(response == exp, "R7 response held while idle", 128'(response), 128'(exp));
        check(no_done, "R6 no done without start", 128'(no_done), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N_PAIR-1:0] first_exp;
        for (int i = 0; i < N_OSC; i++) period_ns[i] = P_TIE;
        test_reset();
        test_alternating(first_exp);
        test_mixed_ties(first_exp);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule